// File: doc/BRIEF.md
# TDM Signalling Channel Serial Receiver

This block takes a signalling channel that rides in one timeslot of a serial TDM stream and turns it into bytes. Timeslot extraction sits upstream and reduces to a strobe: each cycle with `bit_valid` high delivers one channel bit on `bit_in`. Bits are shifted into bytes least significant bit first. Each finished byte is written into a 16-byte receive FIFO, and a processor port pops that FIFO. The bits can arrive as a raw stream or inside asynchronous-style framing, which is a start bit, eight data bits, an optional even parity bit and a stop bit.

Sticky status bits record overrun, parity error, stop-bit error and a data event. The processor clears them by writing ones. The data event has two meanings, chosen by the mode input. In FIFO-level mode it fires when the FIFO fill reaches a programmed threshold. In message-length mode it fires when a message of the programmed number of bytes has been received. One interrupt line combines the data event and the error bits, and each of the two is gated by its own enable.

Top module: `tdm_sig_rx`

## Requirements
- R1: With `frame_en`=0, every eight valid bits after `rx_en` rises form one byte, first bit in bit 0, and that byte is written to the FIFO.
- R2: With `frame_en`=1, the receiver ignores '1' bits while hunting. The first '0' is the start bit. The next eight valid bits are data (LSB first), and the byte is stored once the stop bit has been received.
- R3: With framing and `parity_en` both set, a parity bit follows the data. Parity is even: when the data ones plus the parity bit give an odd total, status bit 1 (parity error) is set. With `frame_en`=0 no parity bit is taken and bit 1 is never set, whatever `parity_en` is.
- R4: A stop bit received as '0' sets status bit 2 (stop error). The byte is still stored.
- R5: The FIFO holds 16 bytes and returns them in arrival order. `rd_data` shows the oldest byte while `fifo_empty` is low, and `rd_en` pops it. A pop while the FIFO is empty has no effect.
- R6: A byte that completes while the FIFO is full, with no pop in the same cycle, is discarded, `fifo_count` stays at 16, and status bit 0 (overrun) is set.
- R7: With `msg_mode`=0, status bit 3 (data event) is set when an accepted write brings the FIFO count to exactly the threshold. A threshold of 0 means 16.
- R8: With `msg_mode`=1, status bit 3 is set when the N-th byte of a message completes, where N is the threshold (0 means 16). The byte count then restarts at zero for the next message.
- R9: Status bits stay set until a write of 1 to the matching `stat_clr` bit. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: `irq` = (`data_ie` AND status bit 3) OR (`err_ie` AND any of status bits 0..2).
- R11: Bits without `bit_valid` are ignored. Dropping `rx_en` discards a partial byte and clears the message byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| frame_en | input | 1 | Start/stop framing enable |
| parity_en | input | 1 | Parity bit enable (framed only) |
| msg_mode | input | 1 | 1 = message-length mode, 0 = FIFO-level mode |
| threshold | input | 4 | Level or message length, 0 means 16 |
| bit_valid | input | 1 | Channel bit strobe |
| bit_in | input | 1 | Channel bit |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Oldest FIFO byte |
| fifo_count | output | 5 | Bytes held |
| fifo_empty | output | 1 | FIFO empty |
| stat_clr | input | 4 | Write-one-to-clear of status bits |
| status | output | 4 | {data event, stop error, parity error, overrun} |
| data_ie | input | 1 | Data event interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Overrun is the hardest condition to reach from the ports. It can only happen after sixteen bytes, 128 strobed bits, have gone in without a single pop. The stimulus fills the FIFO with a run of raw bytes and then sends a seventeenth. It then drains the FIFO to confirm that the first sixteen came back in order and the extra one was dropped. Parity and stop errors need deliberately malformed frames, so the framed-byte task takes flags that invert the parity bit or force the stop bit low.

// File: rtl/tdm_sig_rx_pkg.sv
// Package: shared types and status bit positions for the TDM signalling receiver.
// Assumes: status vector ordering is fixed and visible to software.
package tdm_sig_rx_pkg;
    localparam int ST_OVR = 0;  // overrun
    localparam int ST_PAR = 1;  // parity error
    localparam int ST_STP = 2;  // stop-bit error
    localparam int ST_DAT = 3;  // data event (level reached or message done)
    localparam int ST_W   = 4;

    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_DATA = 2'd1,
        S_PAR  = 2'd2,
        S_STOP = 2'd3
    } rx_state_e;
endpackage

// File: rtl/tdm_sig_rx_deser.sv
// Deserialiser: turns strobed channel bits into bytes, LSB first.
// Framed: hunts for a '0' start bit, takes DATA_W data bits, an optional
// even parity bit and a stop bit. Unframed: every DATA_W bits form a byte.
// Assumes: frame_en and parity_en are static while rx_en is high.
module tdm_sig_rx_deser
    import tdm_sig_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              frame_en,
    input  logic              parity_en,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_perr,
    output logic              byte_serr
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [DATA_W-1:0] shifted;

    // New bit enters at the top, so the first bit ends at bit 0.
    assign shifted = {bit_in, shreg[DATA_W-1:1]};

    // Bit-level state machine and byte emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_HUNT;
            cnt       <= '0;
            shreg     <= '0;
            par_q     <= 1'b0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            byte_perr <= 1'b0;
            byte_serr <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (!rx_en) begin
                state <= S_HUNT;
                cnt   <= '0;
                par_q <= 1'b0;
            end else if (bit_valid) begin
                case (state)
                    S_HUNT: begin
                        if (!frame_en) begin
                            shreg <= shifted;
                            cnt   <= CNT_W'(1);
                            state <= S_DATA;
                        end else if (!bit_in) begin
                            cnt   <= '0;
                            par_q <= 1'b0;
                            state <= S_DATA;
                        end
                    end
                    S_DATA: begin
                        shreg <= shifted;
                        cnt   <= cnt + CNT_W'(1);
                        if (cnt == LAST) begin
                            cnt <= '0;
                            if (!frame_en) begin
                                byte_vld  <= 1'b1;
                                byte_data <= shifted;
                                byte_perr <= 1'b0;
                                byte_serr <= 1'b0;
                                state     <= S_HUNT;
                            end else begin
                                state <= parity_en ? S_PAR : S_STOP;
                            end
                        end
                    end
                    S_PAR: begin
                        par_q <= (^shreg) ^ bit_in;
                        state <= S_STOP;
                    end
                    S_STOP: begin
                        byte_vld  <= 1'b1;
                        byte_data <= shreg;
                        byte_perr <= par_q;
                        byte_serr <= ~bit_in;
                        state     <= S_HUNT;
                    end
                    default: state <= S_HUNT;
                endcase
            end
        end
    end

    // R3: an unframed byte never carries a parity error.
    assert_no_parity_unframed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !$past(frame_en)) |-> !byte_perr);

    // R1: a byte strobe lasts one cycle, since a byte needs several bits.
    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    // R11: without a bit strobe the bit state does not advance.
    assert_hold_without_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && rx_en) |=> ($stable(state) && $stable(cnt)));
endmodule

// File: rtl/tdm_sig_rx_fifo.sv
// Receive FIFO: DEPTH entries, show-ahead read data.
// A write into a full FIFO is dropped unless a pop happens in the same
// cycle; the drop is reported on ovf for one cycle.
// Assumes: DEPTH is a power of two.
module tdm_sig_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_req,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_req,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full,
    output logic                       wr_ok,
    output logic                       rd_ok,
    output logic                       ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;

    // Flags and accept decisions.
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign rd_ok   = rd_req && !empty;
    assign wr_ok   = wr_req && (!full || rd_ok);
    assign ovf     = wr_req && !wr_ok;
    assign rd_data = mem[rptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + AW'(1);
            if (rd_ok) rptr <= rptr + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R6: occupancy never exceeds the depth.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R6: a dropped byte leaves the occupancy unchanged.
    assert_drop_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !rd_req) |=> $stable(count));

    // R5: a pop on an empty FIFO with no write leaves it empty.
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty && !wr_req) |=> empty);
endmodule

// File: rtl/tdm_sig_rx_event.sv
// Event and status logic: sets sticky status bits from byte results,
// FIFO overrun and the mode-dependent data event; clears on write-one;
// combines the enabled causes into one interrupt line.
// Assumes: a threshold value of zero stands for the full FIFO depth.
module tdm_sig_rx_event
    import tdm_sig_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TH_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_en,
    input  logic                   msg_mode,
    input  logic [TH_W-1:0]        threshold,
    input  logic                   byte_vld,
    input  logic                   byte_perr,
    input  logic                   byte_serr,
    input  logic                   wr_ok,
    input  logic                   rd_ok,
    input  logic                   ovf,
    input  logic [$clog2(DEPTH):0] count,
    input  logic [ST_W-1:0]        stat_clr,
    input  logic                   data_ie,
    input  logic                   err_ie,
    output logic [ST_W-1:0]        status,
    output logic                   irq
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam int XW = CW + 1;

    logic [XW-1:0]   level;
    logic [XW-1:0]   cnt_next;
    logic [XW-1:0]   msg_cnt;
    logic            level_hit;
    logic            msg_done;
    logic [ST_W-1:0] set_vec;

    // Decode threshold: zero means the full depth.
    assign level = (threshold == '0) ? XW'(DEPTH) : XW'(threshold);

    // Occupancy after this cycle's write and pop.
    assign cnt_next = XW'(count) + XW'(wr_ok) - XW'(rd_ok);

    // Mode-dependent data event.
    assign level_hit = !msg_mode && wr_ok && (cnt_next == level);
    assign msg_done  = msg_mode && byte_vld && ((msg_cnt + XW'(1)) == level);

    // Collect the set causes for this cycle.
    always_comb begin
        set_vec         = '0;
        set_vec[ST_OVR] = ovf;
        set_vec[ST_PAR] = byte_vld && byte_perr;
        set_vec[ST_STP] = byte_vld && byte_serr;
        set_vec[ST_DAT] = level_hit || msg_done;
    end

    // Message byte counter, restarted after each full message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_cnt <= '0;
        end else if (!rx_en || !msg_mode) begin
            msg_cnt <= '0;
        end else if (byte_vld) begin
            msg_cnt <= msg_done ? '0 : msg_cnt + XW'(1);
        end
    end

    // Sticky status with write-one-to-clear; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~stat_clr) | set_vec;
    end

    // Interrupt line from the enabled causes.
    assign irq = (data_ie && status[ST_DAT]) ||
                 (err_ie && (status[ST_OVR] || status[ST_PAR] || status[ST_STP]));

    // R9: a set bit stays set unless cleared.
    for (genvar i = 0; i < ST_W; i++) begin : g_sticky
        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !stat_clr[i]) |=> status[i]);
    end

    // R10: with both enables low the line stays quiet.
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ie && !err_ie) |-> !irq);

    // R8: the message counter stays below the message length.
    assert_msg_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_cnt < level);
endmodule

// File: rtl/tdm_sig_rx.sv
// Top: TDM signalling channel receiver. Connects the deserialiser, the
// receive FIFO and the event/status logic.
// Assumes: timeslot extraction upstream delivers one bit per bit_valid.
module tdm_sig_rx
    import tdm_sig_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int TH_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_en,
    input  logic                   frame_en,
    input  logic                   parity_en,
    input  logic                   msg_mode,
    input  logic [TH_W-1:0]        threshold,
    input  logic                   bit_valid,
    input  logic                   bit_in,
    input  logic                   rd_en,
    output logic [DATA_W-1:0]      rd_data,
    output logic [$clog2(DEPTH):0] fifo_count,
    output logic                   fifo_empty,
    input  logic [ST_W-1:0]        stat_clr,
    output logic [ST_W-1:0]        status,
    input  logic                   data_ie,
    input  logic                   err_ie,
    output logic                   irq
);
    logic              byte_vld;
    logic [DATA_W-1:0] byte_data;
    logic              byte_perr;
    logic              byte_serr;
    logic              fifo_full;
    logic              wr_ok;
    logic              rd_ok;
    logic              ovf;

    tdm_sig_rx_deser #(.DATA_W(DATA_W)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .frame_en  (frame_en),
        .parity_en (parity_en),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_perr (byte_perr),
        .byte_serr (byte_serr)
    );

    tdm_sig_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (byte_vld),
        .wr_data (byte_data),
        .rd_req  (rd_en),
        .rd_data (rd_data),
        .count   (fifo_count),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .ovf     (ovf)
    );

    tdm_sig_rx_event #(.DEPTH(DEPTH), .TH_W(TH_W)) u_event (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .msg_mode  (msg_mode),
        .threshold (threshold),
        .byte_vld  (byte_vld),
        .byte_perr (byte_perr),
        .byte_serr (byte_serr),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .ovf       (ovf),
        .count     (fifo_count),
        .stat_clr  (stat_clr),
        .data_ie   (data_ie),
        .err_ie    (err_ie),
        .status    (status),
        .irq       (irq)
    );

    // R6: an overrun only happens while the FIFO reports full.
    assert_ovf_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> fifo_full);
endmodule

// File: tb/tdm_sig_rx_tb.sv
module tdm_sig_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, frame_en = 1'b0, parity_en = 1'b0, msg_mode = 1'b0;
    logic [3:0] threshold = 4'd0;
    logic       bit_valid = 1'b0, bit_in = 1'b1, rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] fifo_count;
    logic       fifo_empty;
    logic [3:0] stat_clr = 4'd0;
    logic [3:0] status;
    logic       data_ie = 1'b0, err_ie = 1'b0;
    logic       irq;
    int         checks = 0;
    int         fails  = 0;

    always #2 clk = ~clk;  // 250 MHz

    tdm_sig_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frame_en(frame_en),
        .parity_en(parity_en), .msg_mode(msg_mode), .threshold(threshold),
        .bit_valid(bit_valid), .bit_in(bit_in), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_count(fifo_count), .fifo_empty(fifo_empty), .stat_clr(stat_clr),
        .status(status), .data_ie(data_ie), .err_ie(err_ie), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
        @(negedge clk); bit_valid = 1'b0; bit_in = 1'b1;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic send_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        settle();
    endtask

    task automatic send_framed(input logic [7:0] v, input logic bad_par, input logic stop_b);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        if (parity_en) send_bit((^v) ^ bad_par);
        send_bit(stop_b);
        settle();
    endtask

    task automatic pop(input logic [7:0] exp, input string tag);
        @(negedge clk);
        check(tag, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic clear_status(input logic [3:0] m);
        @(negedge clk); stat_clr = m;
        @(negedge clk); stat_clr = 4'd0;
    endtask

    task automatic set_rx(input logic en);
        @(negedge clk); rx_en = en;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R5 reset empty", fifo_empty, 1'b1);
        check("R5 reset count", fifo_count, 5'd0);
        check("R9 reset status", status, 4'd0);
        check("R10 reset irq", irq, 1'b0);
    endtask

    task automatic t_unframed();
        frame_en = 1'b0; parity_en = 1'b1;
        set_rx(1'b1);
        send_raw(8'hA5);
        send_raw(8'h3C);
        set_rx(1'b0);
        check("R1 count after two bytes", fifo_count, 5'd2);
        pop(8'hA5, "R1 first raw byte");
        pop(8'h3C, "R1 second raw byte");
        check("R3 no parity check unframed", status[1], 1'b0);
    endtask

    task automatic t_framed();
        frame_en = 1'b1; parity_en = 1'b0;
        set_rx(1'b1);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        settle();
        check("R2 idle ones ignored", fifo_count, 5'd0);
        send_framed(8'h5A, 1'b0, 1'b1);
        set_rx(1'b0);
        pop(8'h5A, "R2 framed byte");
        check("R2 no errors", status, 4'd0);
    endtask

    task automatic t_parity();
        frame_en = 1'b1; parity_en = 1'b1;
        set_rx(1'b1);
        send_framed(8'h07, 1'b0, 1'b1);
        check("R3 good parity no error", status[1], 1'b0);
        send_framed(8'h07, 1'b1, 1'b1);
        check("R3 bad parity sets bit1", status[1], 1'b1);
        set_rx(1'b0);
        pop(8'h07, "R3 byte A");
        pop(8'h07, "R3 byte B stored");
    endtask

    task automatic t_stop();
        frame_en = 1'b1; parity_en = 1'b0;
        set_rx(1'b1);
        send_framed(8'hC3, 1'b0, 1'b0);
        set_rx(1'b0);
        check("R4 stop error bit2", status[2], 1'b1);
        pop(8'hC3, "R4 byte kept");
    endtask

    task automatic t_clear_irq();
        err_ie = 1'b0;
        @(negedge clk);
        check("R10 error masked", irq, 1'b0);
        err_ie = 1'b1;
        @(negedge clk);
        check("R10 error enabled", irq, 1'b1);
        clear_status(4'b0010);
        check("R9 clear bit1 keeps bit2", status[2:1], 2'b10);
        clear_status(4'b1111);
        check("R9 all cleared", status, 4'd0);
        check("R10 irq drops", irq, 1'b0);
        err_ie = 1'b0;
    endtask

    task automatic t_overrun();
        frame_en = 1'b0; msg_mode = 1'b0; threshold = 4'd0;
        set_rx(1'b1);
        for (int i = 0; i < 17; i++) send_raw(8'(i * 7 + 1));
        set_rx(1'b0);
        check("R6 count capped", fifo_count, 5'd16);
        check("R6 overrun bit0", status[0], 1'b1);
        for (int i = 0; i < 16; i++) pop(8'(i * 7 + 1), "R5 order");
        check("R6 extra byte dropped", fifo_empty, 1'b1);
        pop(rd_data, "R5 pop on empty");
        check("R5 empty pop no effect", fifo_count, 5'd0);
        clear_status(4'b1111);
    endtask

    task automatic t_level();
        frame_en = 1'b0; msg_mode = 1'b0; threshold = 4'd3; data_ie = 1'b1;
        set_rx(1'b1);
        send_raw(8'h11);
        send_raw(8'h22);
        check("R7 below level", status[3], 1'b0);
        send_raw(8'h33);
        check("R7 level reached", status[3], 1'b1);
        check("R10 data irq", irq, 1'b1);
        set_rx(1'b0);
        for (int i = 0; i < 3; i++) pop(8'(8'h11 * (i + 1)), "R7 drain");
        clear_status(4'b1111);
        data_ie = 1'b0;
    endtask

    task automatic t_message();
        frame_en = 1'b0; msg_mode = 1'b1; threshold = 4'd2;
        set_rx(1'b1);
        send_raw(8'h01);
        check("R8 one of two", status[3], 1'b0);
        send_raw(8'h02);
        check("R8 message done", status[3], 1'b1);
        clear_status(4'b1000);
        send_raw(8'h03);
        check("R8 counter restarted", status[3], 1'b0);
        send_raw(8'h04);
        check("R8 second message", status[3], 1'b1);
        set_rx(1'b0);
        for (int i = 1; i <= 4; i++) pop(8'(i), "R8 drain");
        clear_status(4'b1111);
        msg_mode = 1'b0;
    endtask

    task automatic t_gating();
        frame_en = 1'b0;
        set_rx(1'b1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); bit_in = i[0];
        end
        settle();
        check("R11 unstrobed bits ignored", fifo_count, 5'd0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        set_rx(1'b0);
        set_rx(1'b1);
        send_raw(8'h96);
        set_rx(1'b0);
        check("R11 partial byte dropped", fifo_count, 5'd1);
        pop(8'h96, "R11 realigned byte");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unframed();
        t_framed();
        t_parity();
        t_stop();
        t_clear_irq();
        t_overrun();
        t_level();
        t_message();
        t_gating();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule